// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller split into two independent banks of pins: a core bank and a resume bank. Each bank has its own set of byte-wide registers. Per pin they hold a pin enable, a direction, a level, rising and falling edge enables, an interrupt route enable, two further route enables for system-management and non-maskable signalling, and a sticky trigger status bit. Pads appear as separate input, output and output-enable vectors.

Pad inputs are synchronized by two flops. An edge seen on an enabled input pin whose matching edge enable is set raises that pin's status bit. The bit stays set until software writes a 1 to it. Both banks feed one shared interrupt line. The line is high while any pin has both its status bit and its interrupt route enable set.

The host reaches the registers through a simple 8-bit port. Writes take effect on the clock edge. Reads are combinational from the address. Pin n of any register sits in the byte at that register's offset plus n/8, at bit n%8.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, every direction register reads all ones on implemented pins, and every other register reads 0. The irq output is low and all pad output enables are low.
- R2: Register offsets are fixed. Core bank: pin enable 0x00, direction 0x04, level 0x08, rising enable 0x0C, falling enable 0x10, interrupt route 0x14, system-management route 0x18, status 0x1C, non-maskable route 0x40. Resume bank: the same sequence at 0x20 through 0x3C, with non-maskable route at 0x44. Pin n is in byte offset+n/8, bit n%8, and a written byte reads back masked to implemented pins.
- R3: A pin drives its pad (pad_oe high) only when its enable bit is 1 and its direction bit is 0. pad_out always carries the level register. Neither output changes in a cycle with no host write.
- R4: For a pin with direction 1, reading the level register returns the pad value after two flops of synchronization. For a pin with direction 0, it returns the level register.
- R5: When a pad rises or falls, the status bit sets on the third rising clock edge after the pad change, provided the matching edge enable is set. With both enables set, either edge sets it. With neither set, no edge does.
- R6: Edges are ignored on pins whose enable bit is 0 or whose direction bit is 0.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: If a new edge and a clearing write reach the same status bit on the same clock edge, the bit ends up set.
- R9: irq is high exactly while some pin in either bank has both its status bit and its interrupt route bit set. It stays high until a host write clears that condition.
- R10: Unimplemented offsets, and bits above the pin count, read as 0. Writes to them are ignored.
- R11: The system-management and non-maskable route registers are read/write storage. They do not affect irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Register byte address |
| host_wr | input | 1 | Write strobe, sampled on the clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| core_pad_in | input | CORE_PINS | Core bank pad inputs |
| core_pad_out | output | CORE_PINS | Core bank pad output values |
| core_pad_oe | output | CORE_PINS | Core bank pad output enables |
| res_pad_in | input | RES_PINS | Resume bank pad inputs |
| res_pad_out | output | RES_PINS | Resume bank pad output values |
| res_pad_oe | output | RES_PINS | Resume bank pad output enables |
| irq | output | 1 | Shared interrupt, level high |

## Verification
The properties assume that the only ways to alter configuration or clear status are host writes and reset. Under that assumption, pad outputs and a raised irq stay stable in any cycle without host_wr. The properties also assume host_addr is a known value whenever it is sampled. The stimulus changes host signals and pads only on the falling clock edge and keeps host_wr low outside single-cycle writes. Pad changes are spaced at least three cycles apart, so each edge reaches its status bit before the next pad change, except in the one test that lines an edge up deliberately with a clearing write.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

    localparam int MAX_PINS = 32;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;

    // Register select; the first eight values follow the 4-byte stride of the map.
    typedef enum logic [3:0] {
        SEL_EN    = 4'd0,
        SEL_DIR   = 4'd1,
        SEL_LVL   = 4'd2,
        SEL_RISE  = 4'd3,
        SEL_FALL  = 4'd4,
        SEL_ROUTE = 4'd5,
        SEL_SMI   = 4'd6,
        SEL_STAT  = 4'd7,
        SEL_NMI   = 4'd8,
        SEL_NONE  = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     bank;      // 0 core, 1 resume
        reg_sel_e sel;
        logic [1:0] byte_idx;
    } host_acc_t;

    typedef struct packed {
        logic [MAX_PINS-1:0] en;
        logic [MAX_PINS-1:0] dir;
        logic [MAX_PINS-1:0] lvl;
        logic [MAX_PINS-1:0] rise;
        logic [MAX_PINS-1:0] fall;
        logic [MAX_PINS-1:0] route;
        logic [MAX_PINS-1:0] smi;
        logic [MAX_PINS-1:0] nmi;
    } bank_cfg_t;

    function automatic host_acc_t decode_addr(input logic [ADDR_W-1:0] a);
        host_acc_t r;
        r.hit      = 1'b0;
        r.bank     = 1'b0;
        r.sel      = SEL_NONE;
        r.byte_idx = a[1:0];
        if (a[7:6] == 2'b00) begin
            r.hit  = 1'b1;
            r.bank = a[5];
            r.sel  = reg_sel_e'({1'b0, a[4:2]});
        end else if (a[7:3] == 5'b01000) begin
            r.hit  = 1'b1;
            r.bank = a[2];
            r.sel  = SEL_NMI;
        end
        return r;
    endfunction

    function automatic logic [MAX_PINS-1:0] pin_mask(input int n);
        if (n >= MAX_PINS) return '1;
        return (32'd1 << n) - 32'd1;
    endfunction

    function automatic logic [MAX_PINS-1:0] put_byte(input logic [MAX_PINS-1:0] old,
                                                     input logic [1:0] idx,
                                                     input logic [DATA_W-1:0] d);
        logic [MAX_PINS-1:0] r;
        r = old;
        r[idx*8 +: 8] = d;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] get_byte(input logic [MAX_PINS-1:0] v,
                                                   input logic [1:0] idx);
        return v[idx*8 +: 8];
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_i,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] rise_o,
    output logic [NPINS-1:0] fall_o
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pad_i[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign sync_o[i] = sync_q;
        assign rise_o[i] = sync_q & ~prev_q;
        assign fall_o[i] = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_dual_pkg::*;
#(
    parameter int NPINS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  reg_sel_e            sel_i,
    input  logic [1:0]          byte_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NPINS-1:0]    sync_i,
    input  logic [NPINS-1:0]    rise_i,
    input  logic [NPINS-1:0]    fall_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NPINS-1:0]    pad_out_o,
    output logic [NPINS-1:0]    pad_oe_o,
    output logic                irq_req_o
);
    localparam logic [MAX_PINS-1:0] PIN_MASK = pin_mask(NPINS);

    bank_cfg_t           cfg_q;
    logic [MAX_PINS-1:0] stat_q;
    logic [MAX_PINS-1:0] sync_w, rise_w, fall_w;
    logic [MAX_PINS-1:0] clr_w, evt_w, lvl_view, oe_w;
    logic [MAX_PINS-1:0] wr_val;

    assign sync_w = MAX_PINS'(sync_i);
    assign rise_w = MAX_PINS'(rise_i);
    assign fall_w = MAX_PINS'(fall_i);

    always_comb begin
        case (sel_i)
            SEL_EN:    wr_val = put_byte(cfg_q.en,    byte_i, wdata_i);
            SEL_DIR:   wr_val = put_byte(cfg_q.dir,   byte_i, wdata_i);
            SEL_LVL:   wr_val = put_byte(cfg_q.lvl,   byte_i, wdata_i);
            SEL_RISE:  wr_val = put_byte(cfg_q.rise,  byte_i, wdata_i);
            SEL_FALL:  wr_val = put_byte(cfg_q.fall,  byte_i, wdata_i);
            SEL_ROUTE: wr_val = put_byte(cfg_q.route, byte_i, wdata_i);
            SEL_SMI:   wr_val = put_byte(cfg_q.smi,   byte_i, wdata_i);
            SEL_NMI:   wr_val = put_byte(cfg_q.nmi,   byte_i, wdata_i);
            default:   wr_val = '0;
        endcase
        wr_val = wr_val & PIN_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            cfg_q.dir <= PIN_MASK;
        end else if (wr_i) begin
            case (sel_i)
                SEL_EN:    cfg_q.en    <= wr_val;
                SEL_DIR:   cfg_q.dir   <= wr_val;
                SEL_LVL:   cfg_q.lvl   <= wr_val;
                SEL_RISE:  cfg_q.rise  <= wr_val;
                SEL_FALL:  cfg_q.fall  <= wr_val;
                SEL_ROUTE: cfg_q.route <= wr_val;
                SEL_SMI:   cfg_q.smi   <= wr_val;
                SEL_NMI:   cfg_q.nmi   <= wr_val;
                default: ;
            endcase
        end
    end

    // Sticky status: write-one clears, a same-cycle event takes priority.
    assign clr_w = (wr_i && sel_i == SEL_STAT) ? put_byte('0, byte_i, wdata_i) : '0;
    assign evt_w = cfg_q.en & cfg_q.dir & ((rise_w & cfg_q.rise) | (fall_w & cfg_q.fall));

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= ((stat_q & ~clr_w) | evt_w) & PIN_MASK;
    end

    assign lvl_view = ((cfg_q.dir & sync_w) | (~cfg_q.dir & cfg_q.lvl)) & PIN_MASK;

    always_comb begin
        case (sel_i)
            SEL_EN:    rdata_o = get_byte(cfg_q.en,    byte_i);
            SEL_DIR:   rdata_o = get_byte(cfg_q.dir,   byte_i);
            SEL_LVL:   rdata_o = get_byte(lvl_view,    byte_i);
            SEL_RISE:  rdata_o = get_byte(cfg_q.rise,  byte_i);
            SEL_FALL:  rdata_o = get_byte(cfg_q.fall,  byte_i);
            SEL_ROUTE: rdata_o = get_byte(cfg_q.route, byte_i);
            SEL_SMI:   rdata_o = get_byte(cfg_q.smi,   byte_i);
            SEL_STAT:  rdata_o = get_byte(stat_q,      byte_i);
            SEL_NMI:   rdata_o = get_byte(cfg_q.nmi,   byte_i);
            default:   rdata_o = '0;
        endcase
    end

    assign oe_w      = cfg_q.en & ~cfg_q.dir;
    assign pad_oe_o  = oe_w[NPINS-1:0];
    assign pad_out_o = cfg_q.lvl[NPINS-1:0];
    assign irq_req_o = |(stat_q & cfg_q.route);
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
    import gpio_dual_pkg::*;
#(
    parameter int CORE_PINS = 2,
    parameter int RES_PINS  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_wr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic [CORE_PINS-1:0] core_pad_in,
    output logic [CORE_PINS-1:0] core_pad_out,
    output logic [CORE_PINS-1:0] core_pad_oe,
    input  logic [RES_PINS-1:0]  res_pad_in,
    output logic [RES_PINS-1:0]  res_pad_out,
    output logic [RES_PINS-1:0]  res_pad_oe,
    output logic                 irq
);
    host_acc_t         acc;
    logic              core_wr, res_wr, core_req, res_req;
    logic [DATA_W-1:0] core_rd, res_rd;

    logic [CORE_PINS-1:0] core_sync, core_rise, core_fall;
    logic [RES_PINS-1:0]  res_sync,  res_rise,  res_fall;

    assign acc     = decode_addr(host_addr);
    assign core_wr = host_wr && acc.hit && !acc.bank;
    assign res_wr  = host_wr && acc.hit &&  acc.bank;

    gpio_pad_sync #(.NPINS(CORE_PINS)) u_core_sync (
        .clk(clk), .rst(rst), .pad_i(core_pad_in),
        .sync_o(core_sync), .rise_o(core_rise), .fall_o(core_fall)
    );

    gpio_bank_regs #(.NPINS(CORE_PINS)) u_core_regs (
        .clk(clk), .rst(rst), .wr_i(core_wr), .sel_i(acc.sel),
        .byte_i(acc.byte_idx), .wdata_i(host_wdata),
        .sync_i(core_sync), .rise_i(core_rise), .fall_i(core_fall),
        .rdata_o(core_rd), .pad_out_o(core_pad_out), .pad_oe_o(core_pad_oe),
        .irq_req_o(core_req)
    );

    gpio_pad_sync #(.NPINS(RES_PINS)) u_res_sync (
        .clk(clk), .rst(rst), .pad_i(res_pad_in),
        .sync_o(res_sync), .rise_o(res_rise), .fall_o(res_fall)
    );

    gpio_bank_regs #(.NPINS(RES_PINS)) u_res_regs (
        .clk(clk), .rst(rst), .wr_i(res_wr), .sel_i(acc.sel),
        .byte_i(acc.byte_idx), .wdata_i(host_wdata),
        .sync_i(res_sync), .rise_i(res_rise), .fall_i(res_fall),
        .rdata_o(res_rd), .pad_out_o(res_pad_out), .pad_oe_o(res_pad_oe),
        .irq_req_o(res_req)
    );

    assign host_rdata = !acc.hit ? '0 : (acc.bank ? res_rd : core_rd);
    assign irq        = core_req | res_req;
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
    parameter int CORE_PINS = 2,
    parameter int RES_PINS  = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [7:0]           host_addr,
    input logic                 host_wr,
    input logic [7:0]           host_rdata,
    input logic [CORE_PINS-1:0] core_pad_out,
    input logic [CORE_PINS-1:0] core_pad_oe,
    input logic [RES_PINS-1:0]  res_pad_out,
    input logic [RES_PINS-1:0]  res_pad_oe,
    input logic                 irq
);
    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq && core_pad_oe == '0 && res_pad_oe == '0));

    // R9: a raised interrupt only drops through a host write
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !host_wr) |=> irq);

    // R3: output enables move only after a write
    p_oe_steady_r3: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> ($stable(core_pad_oe) && $stable(res_pad_oe)));

    // R3: output values move only after a write
    p_out_steady_r3: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> ($stable(core_pad_out) && $stable(res_pad_out)));

    // R10: unmapped offsets read zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (host_addr[7:6] != 2'b00 && host_addr[7:3] != 5'b01000) |-> host_rdata == 8'h00);
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.CORE_PINS(CORE_PINS), .RES_PINS(RES_PINS)) chk_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rdata(host_rdata), .core_pad_out(core_pad_out), .core_pad_oe(core_pad_oe),
    .res_pad_out(res_pad_out), .res_pad_oe(res_pad_oe), .irq(irq)
);

// File: tb/gpio_dual_bank_tb.sv
module gpio_dual_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CORE_PINS  = 2;
    localparam int RES_PINS   = 6;
    localparam int WDOG_CYC   = 20000;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // write, read back, compare (R2 map, R10 holes, R11 route storage)
    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{8'h14, 8'hFF, 8'h03, 4'd2},
        '{8'h2C, 8'hFF, 8'h3F, 4'd2},
        '{8'h10, 8'h02, 8'h02, 4'd2},
        '{8'h38, 8'h2A, 8'h2A, 4'd11},
        '{8'h40, 8'hFF, 8'h03, 4'd11},
        '{8'h44, 8'h15, 8'h15, 4'd11},
        '{8'h18, 8'h01, 8'h01, 4'd11},
        '{8'h1D, 8'hFF, 8'h00, 4'd10},
        '{8'h50, 8'hFF, 8'h00, 4'd10},
        '{8'h4C, 8'h5A, 8'h00, 4'd10}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] host_addr = '0;
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [CORE_PINS-1:0] core_pad_in = '0;
    logic [CORE_PINS-1:0] core_pad_out, core_pad_oe;
    logic [RES_PINS-1:0]  res_pad_in = '0;
    logic [RES_PINS-1:0]  res_pad_out, res_pad_oe;
    logic irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_dual_bank #(.CORE_PINS(CORE_PINS), .RES_PINS(RES_PINS)) dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_pad_in(core_pad_in), .core_pad_out(core_pad_out), .core_pad_oe(core_pad_oe),
        .res_pad_in(res_pad_in), .res_pad_out(res_pad_out), .res_pad_oe(res_pad_oe),
        .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        host_addr = a;
        #1;
        chk(req, $sformatf("read %h", a), {24'h0, host_rdata}, {24'h0, exp});
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst = 1'b0;
        wait_neg(1);

        // R1 reset state
        rd_chk("R1", 8'h04, 8'h03);
        rd_chk("R1", 8'h24, 8'h3F);
        rd_chk("R1", 8'h00, 8'h00);
        rd_chk("R1", 8'h3C, 8'h00);
        chk("R1", "irq", {31'h0, irq}, 32'h0);
        chk("R1", "oe", {24'h0, core_pad_oe, res_pad_oe}, 32'h0);

        // table walk: R2 R10 R11
        for (int i = 0; i < NVEC; i++) begin
            wr(TBL[i].addr, TBL[i].wdata);
            rd_chk($sformatf("R%0d", TBL[i].req), TBL[i].addr, TBL[i].exp);
        end
        for (int i = 0; i < NVEC; i++) wr(TBL[i].addr, 8'h00);
        rd_chk("R10", 8'h00, 8'h00);

        // R3 R4: core pin0 input, pin1 output driving 1
        wr(8'h00, 8'h03);
        wr(8'h04, 8'h01);
        wr(8'h08, 8'h02);
        chk("R3", "core_pad_oe", {30'h0, core_pad_oe}, 32'h2);
        chk("R3", "core_pad_out", {30'h0, core_pad_out}, 32'h2);
        rd_chk("R4", 8'h08, 8'h02);
        core_pad_in = 2'b01;
        wait_neg(1);
        rd_chk("R4", 8'h08, 8'h02);
        wait_neg(1);
        rd_chk("R4", 8'h08, 8'h03);

        // R5 R9: resume pin0 rise, pin1 fall, pin2 both, pin3 none
        wr(8'h20, 8'h3F);
        wr(8'h2C, 8'h05);
        wr(8'h30, 8'h06);
        wr(8'h34, 8'h3F);
        res_pad_in[0] = 1'b1;
        wait_neg(2);
        rd_chk("R5", 8'h3C, 8'h00);
        chk("R9", "irq before status", {31'h0, irq}, 32'h0);
        wait_neg(1);
        rd_chk("R5", 8'h3C, 8'h01);
        chk("R9", "irq on status", {31'h0, irq}, 32'h1);
        res_pad_in[1] = 1'b1; wait_neg(3);
        rd_chk("R5", 8'h3C, 8'h01);
        res_pad_in[1] = 1'b0; wait_neg(3);
        rd_chk("R5", 8'h3C, 8'h03);
        res_pad_in[3] = 1'b1; wait_neg(3);
        rd_chk("R5", 8'h3C, 8'h03);
        res_pad_in[2] = 1'b1; wait_neg(3);
        rd_chk("R5", 8'h3C, 8'h07);
        res_pad_in[0] = 1'b0; wait_neg(3);
        rd_chk("R5", 8'h3C, 8'h07);

        // R7 write-one-to-clear
        wr(8'h3C, 8'h00);
        rd_chk("R7", 8'h3C, 8'h07);
        wr(8'h3C, 8'h01);
        rd_chk("R7", 8'h3C, 8'h06);
        chk("R9", "irq with remaining", {31'h0, irq}, 32'h1);
        wr(8'h3C, 8'h06);
        rd_chk("R7", 8'h3C, 8'h00);
        chk("R9", "irq cleared", {31'h0, irq}, 32'h0);

        // R8 edge wins over same-edge clear
        res_pad_in[2] = 1'b0; wait_neg(3);
        rd_chk("R8", 8'h3C, 8'h04);
        wr(8'h3C, 8'h04);
        rd_chk("R8", 8'h3C, 8'h00);
        res_pad_in[2] = 1'b1;
        wait_neg(2);
        host_addr = 8'h3C; host_wdata = 8'h04; host_wr = 1'b1;
        wait_neg(1);
        host_wr = 1'b0;
        rd_chk("R8", 8'h3C, 8'h04);
        wr(8'h3C, 8'h04);
        rd_chk("R7", 8'h3C, 8'h00);

        // R6 disabled pin and output pin ignore edges
        wr(8'h0C, 8'h03);
        wr(8'h14, 8'h03);
        wr(8'h00, 8'h00);
        core_pad_in[0] = 1'b0; wait_neg(3);
        core_pad_in[0] = 1'b1; wait_neg(3);
        rd_chk("R6", 8'h1C, 8'h00);
        chk("R6", "irq disabled pin", {31'h0, irq}, 32'h0);
        wr(8'h00, 8'h03);
        core_pad_in[1] = 1'b1; wait_neg(3);
        rd_chk("R6", 8'h1C, 8'h00);
        core_pad_in[0] = 1'b0; wait_neg(3);
        core_pad_in[0] = 1'b1; wait_neg(3);
        rd_chk("R6", 8'h1C, 8'h01);
        chk("R9", "irq from core bank", {31'h0, irq}, 32'h1);
        wr(8'h1C, 8'h01);
        chk("R9", "irq after core clear", {31'h0, irq}, 32'h0);

        // R11 other routes do not raise irq
        wr(8'h14, 8'h00);
        wr(8'h18, 8'h03);
        wr(8'h40, 8'h03);
        core_pad_in[0] = 1'b0; wait_neg(3);
        core_pad_in[0] = 1'b1; wait_neg(3);
        rd_chk("R11", 8'h1C, 8'h01);
        chk("R11", "irq not routed", {31'h0, irq}, 32'h0);

        // R1 reset in mid-run
        rst = 1'b1;
        wait_neg(2);
        rst = 1'b0;
        wait_neg(1);
        rd_chk("R1", 8'h1C, 8'h00);
        rd_chk("R1", 8'h40, 8'h00);
        rd_chk("R1", 8'h04, 8'h03);
        chk("R1", "oe after reset", {30'h0, core_pad_oe}, 32'h0);
        chk("R1", "irq after reset", {31'h0, irq}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule